// File: doc/BRIEF.md
# Carry-Chained Integer ALU with Hidden Flag

This execution unit performs one integer operation per cycle: add, add with carry, subtract, subtract with borrow, and a multiply-half-then-add in two variants. Operands are 32 or 64 bits wide. A single flag bit kept inside the unit links the operations. It holds the carry out of additions and the borrow out of subtractions. The carry-using forms consume it and can optionally replace it, so a sequence of operations can build sums, differences and products of any number of words. No port reads, sets or clears the flag.

The multiply forms take the full double-width product of `a` and `b` and pick its upper or lower half. They then add `c`, and the flag records the carry out of that addition, not anything from the product. For a signed request the upper half comes from the signed product. The lower half and all add/subtract results do not depend on signedness.

Top module: `ecalu_top`

## Requirements
- R1: Opcode 0 (add) yields d = a + b and always loads the flag with the carry out of the operand width.
- R2: Opcode 1 (add with carry) yields d = a + b + flag. The flag takes the new carry only when `cc_en_i` is 1 and is otherwise kept.
- R3: Opcode 2 (subtract) yields d = a - b and always loads the flag with the borrow, which is 1 exactly when unsigned a < unsigned b.
- R4: Opcode 3 (subtract with borrow) yields d = a - (b + flag). The borrow is 1 when unsigned a < b + flag, evaluated one bit wider than the operands so that b = all-ones with flag = 1 borrows. The flag is written only when `cc_en_i` is 1.
- R5: Opcode 4 (multiply-add) yields d = half(a*b) + c, with the upper half when `hi_i` = 1 and the lower half when `hi_i` = 0. The flag always takes the carry of that final addition.
- R6: Opcode 5 (multiply-add with carry) yields d = half(a*b) + c + flag. The flag takes the carry of that addition only when `cc_en_i` is 1.
- R7: With `wide_i` = 0, only bits 31:0 of each operand are used, the carry or borrow comes from bit 32, and d_o bits 63:32 are zero. With `wide_i` = 1, all 64 bits are used.
- R8: `signed_i` = 1 makes the upper product half come from the signed product. Lower halves, add/subtract results and flags are the same for either value of `signed_i`.
- R9: `valid_o` and `d_o` are registered and appear one cycle after an accepted `valid_i`. An operation issued in the next cycle sees the flag written by the one before it.
- R10: An active-low reset clears the flag, `valid_o` and `d_o` to 0.
- R11: Opcodes 6 and 7 produce d = 0 and leave the flag unchanged.
- R12: A cycle with `valid_i` = 0 leaves the flag and `d_o` unchanged and drives `valid_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (see R1-R6, R11) |
| wide_i | input | 1 | 1 = 64-bit, 0 = 32-bit operands |
| signed_i | input | 1 | Signed product for upper-half selection |
| hi_i | input | 1 | 1 = upper product half, 0 = lower |
| cc_en_i | input | 1 | Flag write enable for the carry-using forms |
| a_i | input | 64 | Operand a |
| b_i | input | 64 | Operand b |
| c_i | input | 64 | Addend c for multiply forms |
| valid_o | output | 1 | Result strobe |
| d_o | output | 64 | Result |

## Verification
The assertions check the following on every cycle: the one-cycle valid latency, that idle cycles hold the flag and result, that carry-using forms keep the flag when the write enable is off, that unknown opcodes give zero and keep the flag, and that upper bits are zero in 32-bit mode. Only the bench scenarios can show the arithmetic values themselves. These include borrow at the extended width, signed against unsigned upper product halves, and multi-word chains in which each step depends on the flag left by the one before.

// File: rtl/ecalu_pkg.sv
package ecalu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBC = 3'd3,
    OP_MAD  = 3'd4,
    OP_MADC = 3'd5
  } op_e;

  typedef struct packed {
    logic known;
    logic sub;
    logic mul;
    logic use_flag;
    logic wr_flag;
  } dec_t;
endpackage

// File: rtl/ecalu_mulhalf.sv
module ecalu_mulhalf #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         signed_i,
  input  logic         hi_i,
  output logic [W-1:0] half_o
);
  logic signed [W:0]     ax, bx;
  logic signed [2*W+1:0] prod;

  // one extra bit lets a single signed multiplier serve both signednesses
  assign ax   = $signed({signed_i & a_i[W-1], a_i});
  assign bx   = $signed({signed_i & b_i[W-1], b_i});
  assign prod = ax * bx;

  assign half_o = hi_i ? prod[2*W-1:W] : prod[W-1:0];
endmodule

// File: rtl/ecalu_addsub.sv
module ecalu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic [W:0] t;

  // W+1-bit arithmetic: bit W is carry, or borrow for subtraction
  always_comb begin
    if (sub_i) t = {1'b0, x_i} - {1'b0, y_i} - {{W{1'b0}}, cin_i};
    else       t = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  end

  assign res_o  = t[W-1:0];
  assign cout_o = t[W];
endmodule

// File: rtl/ecalu_top.sv
module ecalu_top #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic            wide_i,
  input  logic            signed_i,
  input  logic            hi_i,
  input  logic            cc_en_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] c_i,
  output logic            valid_o,
  output logic [XLEN-1:0] d_o
);
  import ecalu_pkg::*;

  localparam int NW     = XLEN / 2;
  localparam int NLANES = 2;

  dec_t            dec;
  logic            flag_q;
  logic            valid_q;
  logic [XLEN-1:0] d_q;
  logic [XLEN-1:0] lane_res [NLANES];
  logic            lane_cout [NLANES];
  logic [XLEN-1:0] sel_res;
  logic            sel_cout;

  always_comb begin
    dec = '0;
    unique case (op_e'(op_i))
      OP_ADD:  dec = '{known: 1'b1, sub: 1'b0, mul: 1'b0, use_flag: 1'b0, wr_flag: 1'b1};
      OP_ADDC: dec = '{known: 1'b1, sub: 1'b0, mul: 1'b0, use_flag: 1'b1, wr_flag: cc_en_i};
      OP_SUB:  dec = '{known: 1'b1, sub: 1'b1, mul: 1'b0, use_flag: 1'b0, wr_flag: 1'b1};
      OP_SUBC: dec = '{known: 1'b1, sub: 1'b1, mul: 1'b0, use_flag: 1'b1, wr_flag: cc_en_i};
      OP_MAD:  dec = '{known: 1'b1, sub: 1'b0, mul: 1'b1, use_flag: 1'b0, wr_flag: 1'b1};
      OP_MADC: dec = '{known: 1'b1, sub: 1'b0, mul: 1'b1, use_flag: 1'b1, wr_flag: cc_en_i};
      default: dec = '0;
    endcase
  end

  // lane 0: narrow (NW bits), lane 1: full XLEN
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NW : XLEN;
    logic [LW-1:0] half, x, y, res;
    logic          cout;

    ecalu_mulhalf #(.W(LW)) u_mul (
      .a_i     (a_i[LW-1:0]),
      .b_i     (b_i[LW-1:0]),
      .signed_i(signed_i),
      .hi_i    (hi_i),
      .half_o  (half)
    );

    assign x = dec.mul ? half : a_i[LW-1:0];
    assign y = dec.mul ? c_i[LW-1:0] : b_i[LW-1:0];

    ecalu_addsub #(.W(LW)) u_add (
      .x_i   (x),
      .y_i   (y),
      .cin_i (dec.use_flag & flag_q),
      .sub_i (dec.sub),
      .res_o (res),
      .cout_o(cout)
    );

    assign lane_res[g]  = XLEN'(res);
    assign lane_cout[g] = cout;
  end

  assign sel_res  = wide_i ? lane_res[1]  : lane_res[0];
  assign sel_cout = wide_i ? lane_cout[1] : lane_cout[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      valid_q <= 1'b0;
      d_q     <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        d_q <= dec.known ? sel_res : '0;
        if (dec.known && dec.wr_flag) flag_q <= sel_cout;
      end
    end
  end

  assign valid_o = valid_q;
  assign d_o     = d_q;
endmodule

// File: rtl/ecalu_chk.sv
module ecalu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [2:0]      op_i,
  input logic            wide_i,
  input logic            cc_en_i,
  input logic            valid_o,
  input logic [XLEN-1:0] d_o,
  input logic            flag_q
);
  localparam int NW = XLEN / 2;

  a_r9_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(flag_q) && $stable(d_o)));

  a_r2_r4_r6_gated_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cc_en_i && (op_i == 3'd1 || op_i == 3'd3 || op_i == 3'd5))
      |=> $stable(flag_q));

  a_r11_bad_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[2] && op_i[1]) |=> (d_o == '0 && $stable(flag_q)));

  a_r7_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> (d_o[XLEN-1:NW] == '0));
endmodule

bind ecalu_top ecalu_chk #(.XLEN(XLEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .op_i   (op_i),
  .wide_i (wide_i),
  .cc_en_i(cc_en_i),
  .valid_o(valid_o),
  .d_o    (d_o),
  .flag_q (flag_q)
);

// File: tb/tb_ecalu_top.sv
`timescale 1ns/1ps
module tb_ecalu_top;
  localparam int XLEN = 64;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [2:0]      op_i = '0;
  logic            wide_i = 1'b0, signed_i = 1'b0, hi_i = 1'b0, cc_en_i = 1'b0;
  logic [XLEN-1:0] a_i = '0, b_i = '0, c_i = '0;
  logic            valid_o;
  logic [XLEN-1:0] d_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecalu_top #(.XLEN(XLEN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .wide_i(wide_i), .signed_i(signed_i), .hi_i(hi_i), .cc_en_i(cc_en_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .valid_o(valid_o), .d_o(d_o)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic [2:0]  op;
    logic        w, s, h, cc;
    logic [63:0] a, b, c, ed;
    logic        ef;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  3'd0, 1'b1, 1'b0, 1'b0, 1'b0, ONES, 64'd1, 64'd0, 64'd0, 1'b1},                         // R1
    '{8'd2,  3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 64'd5, 64'd6, 64'd0, 64'd12, 1'b0},                       // R2
    '{8'd7,  3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h1_FFFF_FFFF, 64'd2, 64'd0, 64'd1, 1'b1},              // R7
    '{8'd2,  3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 64'd1, 64'd1, 64'd0, 64'd3, 1'b1},                        // R2 gated
    '{8'd4,  3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 64'd5, 64'd4, 64'd0, 64'd0, 1'b0},                        // R4
    '{8'd3,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 64'd3, 64'd5, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1},      // R3
    '{8'd4,  3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 64'd0, ONES, 64'd0, 64'd0, 1'b1},                         // R4 wide borrow
    '{8'd4,  3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 64'd7, 64'd2, 64'd0, 64'd4, 1'b0},                        // R4
    '{8'd5,  3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 64'h1_0000, 64'h1_0000, 64'd5, 64'd5, 1'b0},              // R5 lo
    '{8'd5,  3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 64'h1_0000, 64'h1_0000, 64'hFFFF_FFFF, 64'd0, 1'b1},      // R5 hi
    '{8'd8,  3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF, 64'd2, 64'd0, 64'd0, 1'b1},                // R8 signed hi
    '{8'd8,  3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF, 64'd2, 64'd0, 64'd1, 1'b0},                // R8 unsigned hi
    '{8'd6,  3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 64'd3, 64'd4, 64'd1, 64'd13, 1'b0},                       // R6
    '{8'd8,  3'd4, 1'b1, 1'b1, 1'b1, 1'b0, ONES, ONES, 64'd7, 64'd7, 1'b0},                          // R8 wide signed hi
    '{8'd5,  3'd4, 1'b1, 1'b0, 1'b1, 1'b0, ONES, ONES, 64'd2, 64'd0, 1'b1},                          // R5 wide unsigned hi
    '{8'd11, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 64'd1, 64'd1, 64'd1, 64'd0, 1'b1},                        // R11
    '{8'd7,  3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h2_0000_0000, 64'd0, 64'd0, 64'd0, 1'b0},              // R7
    '{8'd8,  3'd0, 1'b1, 1'b1, 1'b0, 1'b0, ONES, ONES, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1},        // R8 add
    '{8'd6,  3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 64'd3, 64'd3, 64'hFFFF_FFF6, 64'd0, 1'b1},                // R6
    '{8'd11, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 64'd9, 64'd9, 64'd9, 64'd0, 1'b1},                        // R11
    '{8'd6,  3'd5, 1'b0, 1'b0, 1'b1, 1'b0, 64'h1_0000, 64'h1_0000, 64'd3, 64'd5, 1'b1}               // R6 gated
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic w, input logic s, input logic h,
                       input logic cc, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] c);
    op_i = op; wide_i = w; signed_i = s; hi_i = h; cc_en_i = cc;
    a_i = a; b_i = b; c_i = c; valid_i = 1'b1;
  endtask

  task automatic issue(input logic [2:0] op, input logic w, input logic s, input logic h,
                       input logic cc, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] c);
    @(negedge clk);
    drive(op, w, s, h, cc, a, b, c);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // reads the flag via add-with-carry of zeros, flag write disabled
  task automatic probe(output logic [63:0] f);
    issue(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'd0, 64'd0, 64'd0);
    f = d_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] f;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid_o", {63'd0, valid_o}, 64'd0);
    check("R10 d_o", d_o, 64'd0);
    rst_ni = 1'b1;
    probe(f);
    check("R10 flag", f, 64'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].w, VECS[i].s, VECS[i].h, VECS[i].cc,
            VECS[i].a, VECS[i].b, VECS[i].c);
      check($sformatf("R%0d d vec%0d", VECS[i].rq, i), d_o, VECS[i].ed);
      check("R9 valid_o", {63'd0, valid_o}, 64'd1);
      probe(f);
      check($sformatf("R%0d flag vec%0d", VECS[i].rq, i), f, {63'd0, VECS[i].ef});
    end

    // R9 back-to-back: dependent addc sees flag from add in the previous cycle
    @(negedge clk);
    drive(3'd0, 1'b1, 1'b0, 1'b0, 1'b0, ONES, 64'd1, 64'd0);
    @(negedge clk);
    drive(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'd0, 64'd0, 64'd0);
    check("R9 first result", d_o, 64'd0);
    @(negedge clk);
    valid_i = 1'b0;
    check("R9 chained carry", d_o, 64'd1);

    // R2 two-word add: {1, ONES} + {0, 1} = {2, 0}
    @(negedge clk);
    drive(3'd0, 1'b1, 1'b0, 1'b0, 1'b0, ONES, 64'd1, 64'd0);
    @(negedge clk);
    drive(3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 64'd1, 64'd0, 64'd0);
    check("R2 low word", d_o, 64'd0);
    @(negedge clk);
    valid_i = 1'b0;
    check("R2 high word", d_o, 64'd2);

    // R12 idle cycles hold result and flag
    issue(3'd0, 1'b1, 1'b0, 1'b0, 1'b0, ONES, 64'd5, 64'd0);
    a_i = 64'd77; op_i = 3'd0;
    repeat (3) @(negedge clk);
    check("R12 valid_o low", {63'd0, valid_o}, 64'd0);
    check("R12 d_o held", d_o, 64'd4);
    probe(f);
    check("R12 flag held", f, 64'd1);

    // R10 reset mid-run clears flag and outputs
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R10 async d_o", d_o, 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    probe(f);
    check("R10 flag after reset", f, 64'd0);

    finish_run();
  end
endmodule